// File: doc/BRIEF.md
# Timer Channel with Output Compare and Edge-Aligned PWM

This block is one channel of a general-purpose timer together with the up-counter that drives it. The counter starts at a programmable start value and counts up to a programmable end value. It then returns to the start value and raises a sticky wrap flag. A single compare value is checked against the counter. A match raises a sticky channel flag, and that flag can request an interrupt.

The channel pin has two modes. In compare mode, each match sets, clears or toggles the pin. In edge-aligned PWM mode, the pin takes its active level at every period start and leaves it at the match. The period is (end − start + 1) clocks and the active width is (compare − start) clocks. A 2-bit edge/level select picks the pin action. When it is 0:0, the pin is released and frozen, but flags and interrupts keep working.

The pin is a two-state machine with the states PIN_LO and PIN_HI. Its transitions are:
- LEAD: to the active level at a PWM period start.
- TRAIL: back to the idle level at the PWM match.
- TOGGLE, SET and CLEAR: compare-mode match actions.
- HOLD: no change, taken when no rule fires or the select is 0:0.

Top module: `tmr_channel`

## Requirements
- R1: While `rst_n` is low, `count` loads `init_val` on each clock. After reset, each clock adds one to `count` while it is below `mod_val`. When `count` is at or above `mod_val`, the next clock loads `init_val`.
- R2: `ovf_flag` becomes 1 on the clock where `count` is at or above `mod_val`. It stays 1 until a clock with `ovf_clr` high and no new wrap. When set and clear happen together, set wins.
- R3: `ch_flag` becomes 1 on the clock where `count` equals `cmp_val`, so it reads 1 one cycle after `count` showed the compare value. It stays 1 until a clock with `chf_clr` high and no new match. When set and clear happen together, set wins.
- R4: `irq` is 1 exactly when `ch_flag` is 1 and `irq_en` is 1. It is combinational.
- R5: With `pwm_mode`=1 and `edge_sel[1]`=1 (1:0 or 1:1), from the first clock after reset `ch_pin` is 1 exactly in the cycles where `count` lies in [`init_val`, `cmp_val`−1]. This gives (cmp − init) high cycles per period.
- R6: With `pwm_mode`=1 and `edge_sel`=0:1, `ch_pin` is the inverse of the R5 level.
- R7: In PWM mode with 1:0, `cmp_val` ≤ `init_val` gives a pin that is always 0. `cmp_val` > `mod_val` gives a pin that is always 1.
- R8: With `pwm_mode`=0 and `edge_sel`=0:1, `ch_pin` inverts on the clock where `count` equals `cmp_val`, so it is visible one cycle later. Otherwise the pin holds.
- R9: With `pwm_mode`=0, a match drives `ch_pin` to 0 with `edge_sel`=1:0 and to 1 with `edge_sel`=1:1.
- R10: With `edge_sel`=0:0, `ch_pin_oe` is 0 and `ch_pin` keeps its value, while R3 and R4 still hold. For any other select value, `ch_pin_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_val | input | CNT_W | Counter start value |
| mod_val | input | CNT_W | Counter end value |
| cmp_val | input | CNT_W | Compare value |
| pwm_mode | input | 1 | 1 = edge-aligned PWM, 0 = output compare |
| edge_sel | input | 2 | Edge/level select, bit 1 = B, bit 0 = A |
| irq_en | input | 1 | Channel interrupt enable |
| ovf_clr | input | 1 | Write-one strobe clearing `ovf_flag` |
| chf_clr | input | 1 | Write-one strobe clearing `ch_flag` |
| count | output | CNT_W | Current counter value |
| ovf_flag | output | 1 | Sticky wrap flag |
| ch_flag | output | 1 | Sticky channel match flag |
| irq | output | 1 | Channel interrupt request |
| ch_pin | output | 1 | Channel pin level |
| ch_pin_oe | output | 1 | Channel pin drive enable |

## Verification
A wrong counter value shows up on `count` on the very next clock. It also shifts every later flag and pin edge. A pin state machine stuck in the wrong state, or taking the wrong transition, shows on `ch_pin` one cycle after the event that should have moved it. In PWM mode it shows by the next period start at the latest. A flag that sets late, clears when a set is pending, or leaks into `irq` while disabled is visible in the cycle right after the match or strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } pin_state_e;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] init_i,
    input  logic [CNT_W-1:0] mod_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        wrap_o    = (cnt_q >= mod_i);
        cnt_nxt_o = wrap_o ? init_i : (cnt_q + ONE);
        cnt_o     = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= init_i;
        else        cnt_q <= cnt_nxt_o;
    end

    assert_wrap_to_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= mod_i) |=> (cnt_q == $past(init_i)));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < mod_i) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_flag_set_wins_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_flag_clears_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_mode_i,
    input  logic [1:0]       els_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             match_i,
    output logic             pin_o,
    output logic             pin_oe_o
);
    pin_state_e state_q, state_d;
    edge_sel_e  sel;
    logic       in_pulse, pwm_lvl, go_hi, go_lo;

    assign sel      = edge_sel_e'(els_i);
    // The next counter value lies in [init, cmp-1]: the pulse is active next cycle.
    assign in_pulse = (cnt_nxt_i < cmp_i);
    assign pwm_lvl  = els_i[1] ? in_pulse : !in_pulse;

    always_comb begin
        go_hi = 1'b0;
        go_lo = 1'b0;
        if (sel != SEL_OFF) begin
            if (pwm_mode_i) begin
                go_hi = pwm_lvl;        // LEAD
                go_lo = !pwm_lvl;       // TRAIL
            end else if (match_i) begin
                unique case (sel)
                    SEL_A:    begin go_hi = 1'b1; go_lo = 1'b1; end  // TOGGLE
                    SEL_B:    go_lo = 1'b1;                          // CLEAR
                    SEL_BOTH: go_hi = 1'b1;                          // SET
                    default:  ;                                      // HOLD
                endcase
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LO: if (go_hi) state_d = PIN_HI;
            PIN_HI: if (go_lo) state_d = PIN_LO;
            default: state_d = PIN_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIN_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        pin_o    = (state_q == PIN_HI);
        pin_oe_o = (sel != SEL_OFF);
    end

    assert_off_holds_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (els_i == 2'b00) |=> (pin_o == $past(pin_o)));

    assert_pwm_trail_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && els_i == 2'b10 && !in_pulse) |=> !pin_o);

    assert_oc_set_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode_i && els_i == 2'b11 && match_i) |=> pin_o);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             pwm_mode,
    input  logic [1:0]       edge_sel,
    input  logic             irq_en,
    input  logic             ovf_clr,
    input  logic             chf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             ch_flag,
    output logic             irq,
    output logic             ch_pin,
    output logic             ch_pin_oe
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap, match;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .init_i(init_val), .mod_i(mod_val),
        .cnt_o(count), .cnt_nxt_o(cnt_nxt), .wrap_o(wrap)
    );

    assign match = (count == cmp_val);

    tmr_flag u_ovf (
        .clk(clk), .rst_n(rst_n), .set_i(wrap), .clr_i(ovf_clr), .flag_o(ovf_flag)
    );

    tmr_flag u_chf (
        .clk(clk), .rst_n(rst_n), .set_i(match), .clr_i(chf_clr), .flag_o(ch_flag)
    );

    assign irq = ch_flag & irq_en;

    tmr_chan_out #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .pwm_mode_i(pwm_mode), .els_i(edge_sel),
        .cnt_nxt_i(cnt_nxt), .cmp_i(cmp_val), .match_i(match),
        .pin_o(ch_pin), .pin_oe_o(ch_pin_oe)
    );

    assert_ovf_after_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= mod_val) |=> ovf_flag);

    assert_chf_after_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == cmp_val) |=> ch_flag);
endmodule

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] init_val = '0, mod_val = '0, cmp_val = '0;
    logic         pwm_mode = 1'b0, irq_en = 1'b0, ovf_clr = 1'b0, chf_clr = 1'b0;
    logic [1:0]   edge_sel = 2'b00;
    logic [W-1:0] count;
    logic         ovf_flag, ch_flag, irq, ch_pin, ch_pin_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tmr_channel #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_val(init_val), .mod_val(mod_val),
        .cmp_val(cmp_val), .pwm_mode(pwm_mode), .edge_sel(edge_sel),
        .irq_en(irq_en), .ovf_clr(ovf_clr), .chf_clr(chf_clr),
        .count(count), .ovf_flag(ovf_flag), .ch_flag(ch_flag), .irq(irq),
        .ch_pin(ch_pin), .ch_pin_oe(ch_pin_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int ini, input int md, input int cp,
                            input logic pm, input logic [1:0] es);
        @(negedge clk);
        rst_n = 1'b0; init_val = W'(ini); mod_val = W'(md); cmp_val = W'(cp);
        pwm_mode = pm; edge_sel = es; irq_en = 1'b0; ovf_clr = 1'b0; chf_clr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset count", int'(count), ini);
        chk("R2 reset ovf_flag", int'(ovf_flag), 0);
        chk("R3 reset ch_flag", int'(ch_flag), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_count(input int v);
        do @(negedge clk); while (int'(count) != v);
    endtask

    task automatic test_counter();
        do_reset(0, 5, 3, 1'b0, 2'b00);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            chk("R1 count sequence", int'(count), k % 6);
            if (k == 5) chk("R2 ovf before wrap", int'(ovf_flag), 0);
            if (k == 6) chk("R2 ovf after wrap", int'(ovf_flag), 1);
        end
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R2 ovf cleared", int'(ovf_flag), 0);
    endtask

    task automatic test_pwm();
        int highs = 0;
        do_reset(2, 6, 4, 1'b1, 2'b10);
        for (int k = 1; k <= 10; k++) begin
            int ec;
            @(negedge clk);
            ec = 2 + (k % 5);
            chk("R1 count from non-zero start", int'(count), ec);
            chk("R5 pwm level", int'(ch_pin), (ec < 4) ? 1 : 0);
            if (k <= 5 && ch_pin) highs++;
        end
        chk("R5 high cycles per period", highs, 2);
        chk("R10 pin enabled", int'(ch_pin_oe), 1);
        edge_sel = 2'b01;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R6 inverted pwm level", int'(ch_pin), (int'(count) < 4) ? 0 : 1);
        end
        edge_sel = 2'b10; cmp_val = W'(2);
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R7 zero duty", int'(ch_pin), 0);
        end
        cmp_val = W'(7);
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R7 full duty", int'(ch_pin), 1);
        end
    endtask

    task automatic test_flags_off();
        do_reset(0, 5, 3, 1'b0, 2'b00);
        wait_count(4);
        chk("R3 flag after match", int'(ch_flag), 1);
        chk("R4 irq masked", int'(irq), 0);
        irq_en = 1'b1;
        #1;
        chk("R4 irq enabled", int'(irq), 1);
        chf_clr = 1'b1;
        @(negedge clk);
        chf_clr = 1'b0;
        chk("R3 flag cleared", int'(ch_flag), 0);
        chk("R4 irq drops with flag", int'(irq), 0);
        wait_count(2);
        chf_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 set wins over clear", int'(ch_flag), 1);
        chf_clr = 1'b0;
        chk("R10 pin released", int'(ch_pin_oe), 0);
        chk("R10 pin frozen through matches", int'(ch_pin), 0);
    endtask

    task automatic test_compare();
        do_reset(0, 5, 3, 1'b0, 2'b01);
        wait_count(3);
        chk("R8 pin before toggle", int'(ch_pin), 0);
        @(negedge clk);
        chk("R8 pin toggled high", int'(ch_pin), 1);
        wait_count(3);
        chk("R8 pin held between matches", int'(ch_pin), 1);
        @(negedge clk);
        chk("R8 pin toggled low", int'(ch_pin), 0);
        edge_sel = 2'b11;
        wait_count(3);
        chk("R9 pin before set", int'(ch_pin), 0);
        @(negedge clk);
        chk("R9 set on match", int'(ch_pin), 1);
        edge_sel = 2'b10;
        wait_count(3);
        chk("R9 pin before clear", int'(ch_pin), 1);
        @(negedge clk);
        chk("R9 clear on match", int'(ch_pin), 0);
    endtask

    initial begin
        test_counter();
        test_pwm();
        test_flags_off();
        test_compare();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule